// File: doc/BRIEF.md
# Masked MAC Address Match Filter

This block is one perfect-filter entry in an Ethernet receive path. It stores a 48-bit station address and a control word, both reachable through a small word-wide register port. While a frame streams in, one byte per valid cycle, the entry captures either the destination address field or the source address field. It compares the captured field with the stored address and skips every byte whose mask bit is set. After the last byte of the chosen field arrives, it reports the result on a single match pulse.

A match pulse requires the enable bit to be set. With bytes masked, one entry accepts a whole group of addresses. The comparison runs against a copy of both registers taken at start of frame, so software can reprogram the entry while a frame is being received without upsetting that frame.

Top module: `mac_addr_match_filter`

## Requirements
- R1: The upper register (reg_sel=1) holds address bits 47:32 in bits 15:0, the byte masks in bits 29:24, source-select in bit 30 and enable in bit 31. Its bits 23:16 always read as zero, whatever value was written to them.
- R2: After reset, the lower register (reg_sel=0, address bits 31:0) reads 0xFFFF_FFFF and the upper register reads 0x0000_FFFF.
- R3: With the enable bit at 0, the match output never asserts.
- R4: With source-select at 0, frame bytes 0..5 are compared. Byte 0 maps to address bits 7:0 and byte 5 maps to address bits 47:40.
- R5: With source-select at 1, frame bytes 6..11 are compared in the same byte order, and bytes 0..5 have no effect.
- R6: Mask bit 24+k set to 1 drops field byte k (address bits 8k+7:8k) from the comparison. Unmasked bytes must still match.
- R7: With all six mask bits set and the entry enabled, every frame that reaches the end of the selected field produces a match.
- R8: A match is a single-cycle pulse. It appears in the cycle after the clock edge that captures the last byte of the selected field.
- R9: rx_eof marks the last byte of a frame. Bytes received after it are ignored until the next rx_sof, so a frame that ends before the selected field is complete gives no pulse.
- R10: A register write made during a frame changes the readback at once, but the comparison for that frame uses the values latched at its start. The new value takes effect from the next rx_sof.
- R11: rx_sof restarts byte counting. A byte presented together with rx_sof is byte 0, even in the middle of an unfinished frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the lower address register, 1 selects the upper control register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| rx_valid | input | 1 | rx_data carries a frame byte this cycle |
| rx_sof | input | 1 | Start of frame. When rx_valid is also high, rx_data is byte 0 |
| rx_eof | input | 1 | With rx_valid, marks the last byte of the frame |
| rx_data | input | 8 | Received frame byte, in wire order |
| match | output | 1 | One-cycle pulse: the selected field matched the entry |

## Verification
The bench builds the block with its default six-byte address width. With that width the capture counter saturates just past byte 11, so both the destination and source fields can be checked in full, including how the counter behaves right at its saturation point. Because mask bits are tied to fixed byte lanes, the bench places single-byte differences in chosen lanes, covering the lowest, a middle and the highest lane. It also places a destination-field copy inside a source-mode frame, which shows whether the lane-to-byte mapping is right.

// File: rtl/maf_pkg.sv
package maf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int REG_W      = 32;
  localparam int EN_BIT     = 31;
  localparam int SRC_BIT    = 30;
  localparam int MASK_LSB   = 24;
  localparam logic [REG_W-1:0] LO_RESET = 32'hFFFF_FFFF;
  localparam logic [REG_W-1:0] HI_RESET = 32'h0000_FFFF;
  localparam logic [REG_W-1:0] HI_WMASK = 32'hFF00_FFFF;

  typedef struct packed {
    logic                  en;
    logic                  src_sel;
    logic [ADDR_BYTES-1:0] mask;
    logic [ADDR_W-1:0]     addr;
  } maf_cfg_t;

  function automatic maf_cfg_t decode_cfg(input logic [REG_W-1:0] lo,
                                          input logic [REG_W-1:0] hi);
    maf_cfg_t c;
    c.en      = hi[EN_BIT];
    c.src_sel = hi[SRC_BIT];
    c.mask    = hi[MASK_LSB +: ADDR_BYTES];
    c.addr    = {hi[15:0], lo};
    return c;
  endfunction

  function automatic logic lane_ok(input logic [7:0] got,
                                   input logic [7:0] want,
                                   input logic       skip);
    return skip || (got == want);
  endfunction
endpackage

// File: rtl/maf_regs.sv
module maf_regs
  import maf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             rx_sof,
  output maf_cfg_t         cfg_eff
);
  logic [REG_W-1:0] lo_q, hi_q, snap_lo_q, snap_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= LO_RESET;
      hi_q <= HI_RESET;
    end else if (reg_we) begin
      if (reg_sel) hi_q <= reg_wdata & HI_WMASK;
      else         lo_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_lo_q <= LO_RESET;
      snap_hi_q <= HI_RESET;
    end else if (rx_sof) begin
      snap_lo_q <= lo_q;
      snap_hi_q <= hi_q;
    end
  end

  assign reg_rdata = reg_sel ? hi_q : lo_q;
  assign cfg_eff   = rx_sof ? decode_cfg(lo_q, hi_q) : decode_cfg(snap_lo_q, snap_hi_q);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_rdata[23:16] == 8'h00)); // R1
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_sof |=> ($stable(snap_lo_q) && $stable(snap_hi_q))); // R10
endmodule

// File: rtl/maf_capture.sv
module maf_capture
  import maf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic              src_sel,
  output logic [ADDR_W-1:0] cap_next,
  output logic              field_last
);
  localparam int IDX_W = $clog2(2 * ADDR_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(2 * ADDR_BYTES);
  localparam logic [IDX_W-1:0] SA_BASE = IDX_W'(ADDR_BYTES);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(ADDR_BYTES - 1);

  logic [IDX_W-1:0]  idx_q, idx_eff, base, slot;
  logic              in_frame_q, accept, in_field;
  logic [ADDR_W-1:0] cap_q;

  assign idx_eff  = rx_sof ? '0 : idx_q;
  assign accept   = rx_valid && (rx_sof || in_frame_q);
  assign base     = src_sel ? SA_BASE : '0;
  assign slot     = idx_eff - base;
  assign in_field = accept && (idx_eff >= base) && (slot <= LAST);
  assign field_last = in_field && (slot == LAST);

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_lane
    assign cap_next[8*k +: 8] = (in_field && slot == IDX_W'(k)) ? rx_data : cap_q[8*k +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      in_frame_q <= 1'b0;
      cap_q      <= '0;
    end else begin
      if (accept) begin
        cap_q <= cap_next;
        idx_q <= (idx_eff == IDX_MAX) ? IDX_MAX : idx_eff + 1'b1;
      end else if (rx_sof) begin
        idx_q <= '0;
      end
      if (accept && rx_eof) in_frame_q <= 1'b0;
      else if (rx_sof)      in_frame_q <= 1'b1;
    end
  end

  AST_NO_FIELD_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame_q && !rx_sof) |-> !field_last); // R9
  AST_SOF_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sof |-> !field_last); // R11
endmodule

// File: rtl/maf_compare.sv
module maf_compare
  import maf_pkg::*;
(
  input  logic [ADDR_W-1:0]     cap,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [ADDR_BYTES-1:0] mask,
  output logic [ADDR_BYTES-1:0] lane_hit,
  output logic                  hit
);
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_cmp
    assign lane_hit[k] = lane_ok(cap[8*k +: 8], addr[8*k +: 8], mask[k]);
  end
  assign hit = &lane_hit;
endmodule

// File: rtl/mac_addr_match_filter.sv
module mac_addr_match_filter
  import maf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_data,
  output logic        match
);
  maf_cfg_t              cfg_eff;
  logic [ADDR_W-1:0]     cap_next;
  logic [ADDR_BYTES-1:0] lane_hit;
  logic                  field_last, field_hit, match_q;

  maf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_sof(rx_sof), .cfg_eff(cfg_eff)
  );

  maf_capture u_capture (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .src_sel(cfg_eff.src_sel), .cap_next(cap_next), .field_last(field_last)
  );

  maf_compare u_compare (
    .cap(cap_next), .addr(cfg_eff.addr), .mask(cfg_eff.mask),
    .lane_hit(lane_hit), .hit(field_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= field_last && cfg_eff.en && field_hit;
  end
  assign match = match_q;

  AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(cfg_eff.en)); // R3
  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (field_last && cfg_eff.en && (&cfg_eff.mask)) |=> match); // R7
  AST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !match); // R8
  AST_MATCH_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(field_last)); // R8
endmodule

// File: tb/mac_addr_match_filter_bench.sv
module mac_addr_match_filter_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 0, reg_sel = 0, rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0]  rx_data = '0;
  logic        match;
  int n_chk = 0, n_bad = 0;
  logic [7:0]  fb [0:13];

  always #4 clk = ~clk;

  mac_addr_match_filter u_mac_addr_match_filter (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .match(match)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    @(negedge clk); reg_sel = sel; #1; d = reg_rdata;
  endtask

  // load the frame buffer: DA, SA, then filler
  task automatic fill(input logic [47:0] da, input logic [47:0] sa);
    for (int k = 0; k < 6; k++) begin fb[k] = da[8*k +: 8]; fb[6+k] = sa[8*k +: 8]; end
    fb[12] = 8'h08; fb[13] = 8'h00;
  endtask

  // drive len bytes; returns number of pulses and byte index of the first pulse
  task automatic send(input int len, input bit with_sof, input bit with_eof, input int wr_at,
                      input logic wsel, input logic [31:0] wd, output int hits, output int first);
    hits = 0; first = -1;
    for (int i = 0; i < len + 3; i++) begin
      @(negedge clk);
      if (match) begin hits++; if (first < 0) first = i - 1; end
      rx_valid = (i < len); rx_data = (i < len) ? fb[i] : 8'h00;
      rx_sof = (i == 0) && with_sof && (len > 0);
      rx_eof = with_eof && (i == len - 1);
      reg_we = (i == wr_at); reg_sel = wsel; reg_wdata = wd;
    end
    reg_we = 0;
  endtask

  function automatic bit model(input logic [31:0] lo, input logic [31:0] hi, input int len);
    int b;
    logic [47:0] a;
    a = {hi[15:0], lo};
    b = hi[30] ? 6 : 0;
    if (!hi[31] || len < b + 6) return 0;
    for (int k = 0; k < 6; k++)
      if (!hi[24+k] && fb[b+k] != a[8*k +: 8]) return 0;
    return 1;
  endfunction

  task automatic frame_case(input logic [31:0] lo, input logic [31:0] hi, input int len,
                            input string tag);
    int h, f;
    bit e;
    e = model(lo, hi, len);
    send(len, 1, 1, -1, 0, 0, h, f);
    check(h == (e ? 1 : 0), {tag, " pulse count"}, h, e);
    if (e) check(f == (hi[30] ? 11 : 5), {tag, " R8 pulse cycle"}, f, hi[30] ? 11 : 5);
  endtask

  localparam logic [47:0] A = 48'hA1B2_C3D4_E5F6;
  localparam logic [47:0] B = 48'h1020_3040_5060;

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d); check(d == 32'hFFFF_FFFF, "R2 low reset", d, 32'hFFFF_FFFF);
    rd(1, d); check(d == 32'h0000_FFFF, "R2 high reset", d, 32'h0000_FFFF);
    fill(48'hFFFF_FFFF_FFFF, B);
    frame_case(32'hFFFF_FFFF, 32'h0000_FFFF, 14, "R3 disabled at reset");
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(1, 32'hFFFF_FFFF); rd(1, d);
    check(d == 32'hFF00_FFFF, "R1 reserved bits zero", d, 32'hFF00_FFFF);
    wr(1, 32'h3F00_1234); rd(1, d);
    check(d == 32'h3F00_1234, "R1 field layout", d, 32'h3F00_1234);
    fill(B, B);
    frame_case(32'hFFFF_FFFF, 32'h3F00_1234, 14, "R3 disabled all masked");
  endtask

  task automatic t_da();
    logic [31:0] hi;
    hi = {16'h8000, A[47:32]};
    wr(0, A[31:0]); wr(1, hi);
    fill(A, B); frame_case(A[31:0], hi, 14, "R4 DA exact");
    fill(A ^ 48'h0100_0000_0000, B); frame_case(A[31:0], hi, 14, "R4 DA byte5 differs");
    fill(A ^ 48'h0000_0000_0001, B); frame_case(A[31:0], hi, 14, "R4 DA byte0 differs");
    fill(A, B); frame_case(A[31:0], hi, 6, "R4 DA-only short frame");
  endtask

  task automatic t_sa();
    logic [31:0] hi;
    hi = {16'hC000, A[47:32]};
    wr(1, hi);
    fill(B, A); frame_case(A[31:0], hi, 14, "R5 SA exact");
    fill(A, B); frame_case(A[31:0], hi, 14, "R5 DA holds addr, SA not");
    fill(B, A ^ 48'h0000_0080_0000); frame_case(A[31:0], hi, 14, "R5 SA byte2 differs");
  endtask

  task automatic t_mask();
    logic [31:0] hi;
    hi = {16'h8400, A[47:32]};
    wr(1, hi);
    fill(A ^ 48'h0000_00FF_0000, B); frame_case(A[31:0], hi, 14, "R6 masked lane2 differs");
    fill(A ^ 48'h0000_FF00_0000, B); frame_case(A[31:0], hi, 14, "R6 unmasked lane3 differs");
    hi = {16'hA000, A[47:32]};
    wr(1, hi);
    fill(A ^ 48'hFF00_0000_0000, B); frame_case(A[31:0], hi, 14, "R6 masked lane5 differs");
    hi = {16'hBF00, A[47:32]};
    wr(1, hi);
    fill(B, B); frame_case(A[31:0], hi, 14, "R7 all masked any DA");
    fill(B, B); frame_case(A[31:0], hi, 4, "R9 all masked short frame");
  endtask

  task automatic t_trunc();
    int h, f;
    logic [31:0] hi;
    hi = {16'h8000, A[47:32]};
    wr(1, hi);
    fill(A, B);
    send(3, 1, 1, -1, 0, 0, h, f);
    fb[0] = fb[3]; fb[1] = fb[4]; fb[2] = fb[5];
    send(3, 0, 0, -1, 0, 0, h, f);
    check(h == 0, "R9 bytes after eof ignored", h, 0);
  endtask

  task automatic t_midwrite();
    int h, f;
    logic [31:0] hi;
    hi = {16'h8000, A[47:32]};
    wr(1, hi);
    fill(A, B);
    send(14, 1, 1, 2, 0, B[31:0], h, f);
    check(h == 1 && f == 5, "R10 old value used mid-frame", h, 1);
    frame_case(B[31:0], hi, 14, "R10 new value next frame A");
    fill({A[47:32], B[31:0]}, B);
    frame_case(B[31:0], hi, 14, "R10 new value next frame match");
    wr(0, A[31:0]);
  endtask

  task automatic t_restart();
    int h, f;
    logic [31:0] hi;
    hi = {16'hC000, A[47:32]};
    wr(1, hi);
    fill(B, B);
    send(8, 1, 0, -1, 0, 0, h, f);
    fill(B, A);
    send(14, 1, 1, -1, 0, 0, h, f);
    check(h == 1 && f == 11, "R11 sof restarts count", f, 11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_reserved();
    t_da();
    t_sa();
    t_mask();
    t_trunc();
    t_midwrite();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule